// File: doc/BRIEF.md
# Store Writeback Drain Controller

The block holds a processor's stores in a circular queue and sends the committed ones, oldest first, to a data-cache request port. Stores enter through a valid/ready enqueue port. A separate commit pulse marks the oldest uncommitted entry as eligible to leave. The cache port is valid/ready as well, but a refusal is final for that cycle. When the cache refuses a request, the controller copies it into a single parked slot and raises a blocked flag. From then on it sends nothing until the cache pulses `req_retry`. In that cycle the parked request is offered again.

A store-conditional is resolved locally against one reservation flag, which a load-linked operation sets. An uncacheable conditional is sent with result code 2. A cacheable one is sent with code 1 when the flag is set. When the flag is clear, it retires at once with code 0 and never reaches the cache. When the cache accepts a store, the controller runs its post-send actions in a fixed order:

1. Release a load stalled on that store's sequence number.
2. Report completion of a plain store.
3. Advance the writeback pointer.

Back-pressure rules:
- The enqueue side accepts a store whenever `enq_ready` is high. `enq_ready` is a registered full test and does not depend on `enq_valid`.
- On the cache side, `req_valid` may fall without a handshake only when the request has been parked.
- While blocked, `req_valid` is high only in a cycle where `req_retry` is high.

Top module: `sq_wb_ctrl`

## Requirements
- R1: Stores leave in enqueue order and only after commit; a commit pulse with no uncommitted entry does nothing. `enq_ready` is low while DEPTH entries are held, and the writeback pointer wraps past the last slot.
- R2: A conditional store marked uncacheable is presented with `req_sc_res` = 2, whatever the reservation flag holds.
- R3: A cacheable conditional store presented while the reservation flag is set carries `req_sc_res` = 1 and `req_noresp` = 0. Its acceptance raises no completion pulse.
- R4: A cacheable conditional store reaching the head while the flag is clear is never presented (`req_valid` stays 0). One cycle later it raises `cmpl_valid` with `cmpl_sc_res` = 0 and `cmpl_cond` = 1. The next store is presented right after it, and this retirement releases no stalled load. A load-linked pulse in the same cycle is not seen by it.
- R5: A `ll_valid` pulse sets `resv_flag` and loads `resv_addr`. A `resv_clr` pulse drops the flag, and `ll_valid` wins when both arrive together.
- R6: A refused request is parked and `st_blocked` rises. While blocked and `req_retry` is low, `req_valid` is 0 even when further committed stores wait.
- R7: In a retry cycle the parked request is presented again. If it is accepted, `st_blocked` falls and queue draining resumes; if it is refused, the block stays.
- R8: `req_retry` while not blocked causes no request and no completion.
- R9: While a load is stalled on sequence number S, acceptance of the store with sequence S clears `stalled`. One cycle after the acceptance, it pulses `replay_valid` with the stored load index.
- R10: A plain store is presented with `req_noresp` = 1. One cycle after it is accepted, `cmpl_valid` pulses with its sequence number and `cmpl_cond` = 0.
- R11: A parked conditional keeps the result code it was first presented with, even if the reservation changes while it is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Store offered to the queue |
| enq_ready | output | 1 | Queue has a free slot |
| enq_addr | input | ADDR_W | Store physical address |
| enq_data | input | DATA_W | Store data |
| enq_seq | input | SEQ_W | Store sequence number |
| enq_cond | input | 1 | Store is conditional |
| enq_uncache | input | 1 | Store targets uncacheable space |
| commit_valid | input | 1 | Commit the oldest uncommitted entry |
| ll_valid | input | 1 | Load-linked executed |
| ll_addr | input | ADDR_W | Load-linked physical address |
| resv_clr | input | 1 | Reservation lost |
| resv_flag | output | 1 | Reservation held |
| resv_addr | output | ADDR_W | Recorded reservation address |
| stall_set | input | 1 | A load stalls on a store |
| stall_seq | input | SEQ_W | Sequence number of the blocking store |
| stall_ldidx | input | LIDX_W | Queue index of the stalled load |
| stalled | output | 1 | A load stall is pending |
| replay_valid | output | 1 | Replay the released load |
| replay_ldidx | output | LIDX_W | Index of the load to replay |
| req_valid | output | 1 | Cache request valid |
| req_ready | input | 1 | Cache accepts the request this cycle |
| req_retry | input | 1 | Cache invites a resend |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_seq | output | SEQ_W | Request sequence number |
| req_cond | output | 1 | Request is a conditional store |
| req_sc_res | output | 2 | Conditional result code (0 fail, 1 success, 2 uncacheable) |
| req_noresp | output | 1 | No writeback response needed |
| st_blocked | output | 1 | A refused request is parked |
| cmpl_valid | output | 1 | A store completed |
| cmpl_seq | output | SEQ_W | Sequence number of the completed store |
| cmpl_cond | output | 1 | Completed store was conditional |
| cmpl_sc_res | output | 2 | Result code of a completed conditional |

## Verification
A load-linked pulse can arrive in the same cycle that a cacheable conditional is resolved at the head of the queue. The reservation is registered, so the conditional must see the old, clear flag and retire as a failure, while the flag still ends up set. The bench provokes this by driving `ll_valid` in the first cycle after the commit edge that exposes the conditional. It then requires `req_valid` to stay low in that cycle, a code-0 completion on the next edge, and `resv_flag` high afterwards. A second overlap is a retry pulse arriving when nothing is parked and the queue is empty; the bench judges that case by the absence of any request or completion.

// File: rtl/sq_wb_pkg.sv
package sq_wb_pkg;

  typedef enum logic [1:0] {
    SC_FAIL = 2'd0,
    SC_OK   = 2'd1,
    SC_UNC  = 2'd2
  } sc_code_e;

  function automatic sc_code_e sc_resolve(input logic uncache, input logic resv);
    if (uncache)   return SC_UNC;
    else if (resv) return SC_OK;
    else           return SC_FAIL;
  endfunction

endpackage

// File: rtl/sq_ring.sv
module sq_ring #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic [ENT_W-1:0] enq_ent,
  output logic             enq_ready,
  input  logic             commit,
  input  logic             pop,
  output logic [ENT_W-1:0] head_ent,
  output logic             has_cmt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] alloc_q, cmt_q, wb_q;
  logic [ENT_W-1:0] slots [DEPTH];
  logic full, enq_fire, cmt_fire;
  logic [PW-1:0] occ;

  assign full      = (alloc_q[AW] != wb_q[AW]) && (alloc_q[AW-1:0] == wb_q[AW-1:0]);
  assign enq_ready = !full;
  assign enq_fire  = enq_valid && !full;
  assign cmt_fire  = commit && (cmt_q != alloc_q);
  assign has_cmt   = (wb_q != cmt_q);
  assign head_ent  = slots[wb_q[AW-1:0]];
  assign occ       = alloc_q - wb_q;

  always_ff @(posedge clk) begin
    if (enq_fire) slots[alloc_q[AW-1:0]] <= enq_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_q <= '0;
      cmt_q   <= '0;
      wb_q    <= '0;
    end else begin
      if (enq_fire) alloc_q <= alloc_q + PW'(1);
      if (cmt_fire) cmt_q   <= cmt_q + PW'(1);
      if (pop)      wb_q    <= wb_q + PW'(1);
    end
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_P);
  a_r1_pop_committed: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> has_cmt);
  a_r1_commit_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_q - wb_q) <= occ);
endmodule

// File: rtl/sq_park.sv
module sq_park #(
  parameter int ENT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             park_en,
  input  logic [ENT_W-1:0] park_ent,
  input  logic [1:0]       park_code,
  input  logic             clear,
  output logic             blocked,
  output logic [ENT_W-1:0] slot_ent,
  output logic [1:0]       slot_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocked   <= 1'b0;
      slot_ent  <= '0;
      slot_code <= '0;
    end else if (park_en) begin
      blocked   <= 1'b1;
      slot_ent  <= park_ent;
      slot_code <= park_code;
    end else if (clear) begin
      blocked   <= 1'b0;
    end
  end

  a_r6_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |-> !blocked);
  a_r11_slot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && $past(blocked)) |-> ($stable(slot_ent) && $stable(slot_code)));
endmodule

// File: rtl/sq_resv.sv
module sq_resv #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              clr,
  output logic              flag,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      addr <= '0;
    end else if (ll_valid) begin
      flag <= 1'b1;
      addr <= ll_addr;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  a_r5_rise_from_ll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(ll_valid));
  a_r5_fall_from_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr && !ll_valid));
endmodule

// File: rtl/sq_stall.sv
module sq_stall #(
  parameter int SEQ_W  = 16,
  parameter int LIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [SEQ_W-1:0]  set_seq,
  input  logic [LIDX_W-1:0] set_idx,
  input  logic              sent,
  input  logic [SEQ_W-1:0]  sent_seq,
  output logic              stalled,
  output logic              replay_valid,
  output logic [LIDX_W-1:0] replay_idx
);
  logic [SEQ_W-1:0]  seq_q;
  logic [LIDX_W-1:0] idx_q;
  logic              release_now;

  assign release_now = sent && stalled && (sent_seq == seq_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stalled      <= 1'b0;
      seq_q        <= '0;
      idx_q        <= '0;
      replay_valid <= 1'b0;
      replay_idx   <= '0;
    end else begin
      replay_valid <= release_now;
      if (release_now) replay_idx <= idx_q;
      if (set) begin
        stalled <= 1'b1;
        seq_q   <= set_seq;
        idx_q   <= set_idx;
      end else if (release_now) begin
        stalled <= 1'b0;
      end
    end
  end

  a_r9_replay_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> $past(stalled));
  a_r9_replay_needs_send: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> $past(sent));
endmodule

// File: rtl/sq_wb_ctrl.sv
module sq_wb_ctrl
  import sq_wb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 16,
  parameter int LIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [DATA_W-1:0] enq_data,
  input  logic [SEQ_W-1:0]  enq_seq,
  input  logic              enq_cond,
  input  logic              enq_uncache,
  input  logic              commit_valid,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              resv_clr,
  output logic              resv_flag,
  output logic [ADDR_W-1:0] resv_addr,
  input  logic              stall_set,
  input  logic [SEQ_W-1:0]  stall_seq,
  input  logic [LIDX_W-1:0] stall_ldidx,
  output logic              stalled,
  output logic              replay_valid,
  output logic [LIDX_W-1:0] replay_ldidx,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              req_retry,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [SEQ_W-1:0]  req_seq,
  output logic              req_cond,
  output logic [1:0]        req_sc_res,
  output logic              req_noresp,
  output logic              st_blocked,
  output logic              cmpl_valid,
  output logic [SEQ_W-1:0]  cmpl_seq,
  output logic              cmpl_cond,
  output logic [1:0]        cmpl_sc_res
);
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [SEQ_W-1:0]  seq;
    logic              cond;
    logic              unc;
  } sq_ent_t;

  localparam int ENT_W = $bits(sq_ent_t);

  sq_ent_t          enq_e, head_e, slot_e, cur_e;
  logic [ENT_W-1:0] head_vec, slot_vec;
  logic [1:0]       head_code, slot_code, cur_code;
  logic             has_cmt, live, sc_fail, accept, park_en, pop;

  assign enq_e = '{addr: enq_addr, data: enq_data, seq: enq_seq,
                   cond: enq_cond, unc: enq_uncache};

  sq_ring #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ent(enq_e), .enq_ready(enq_ready),
    .commit(commit_valid), .pop(pop),
    .head_ent(head_vec), .has_cmt(has_cmt)
  );

  sq_resv #(.ADDR_W(ADDR_W)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_addr(ll_addr), .clr(resv_clr),
    .flag(resv_flag), .addr(resv_addr)
  );

  sq_park #(.ENT_W(ENT_W)) u_park (
    .clk(clk), .rst_n(rst_n),
    .park_en(park_en), .park_ent(cur_e), .park_code(cur_code),
    .clear(st_blocked && accept),
    .blocked(st_blocked), .slot_ent(slot_vec), .slot_code(slot_code)
  );

  sq_stall #(.SEQ_W(SEQ_W), .LIDX_W(LIDX_W)) u_stall (
    .clk(clk), .rst_n(rst_n),
    .set(stall_set), .set_seq(stall_seq), .set_idx(stall_ldidx),
    .sent(accept), .sent_seq(cur_e.seq),
    .stalled(stalled), .replay_valid(replay_valid), .replay_idx(replay_ldidx)
  );

  // Head resolution: the conditional code is taken from the registered flag.
  assign head_e    = sq_ent_t'(head_vec);
  assign slot_e    = sq_ent_t'(slot_vec);
  assign head_code = head_e.cond ? 2'(sc_resolve(head_e.unc, resv_flag)) : 2'd0;
  assign live      = has_cmt && !st_blocked;
  assign sc_fail   = live && head_e.cond && (head_code == 2'(SC_FAIL));

  // The parked copy is offered only in a retry cycle.
  assign cur_e     = st_blocked ? slot_e : head_e;
  assign cur_code  = st_blocked ? slot_code : head_code;
  assign req_valid = st_blocked ? req_retry : (live && !sc_fail);
  assign accept    = req_valid && req_ready;
  assign park_en   = req_valid && !req_ready && !st_blocked;
  assign pop       = accept || sc_fail;

  assign req_addr   = cur_e.addr;
  assign req_data   = cur_e.data;
  assign req_seq    = cur_e.seq;
  assign req_cond   = cur_e.cond;
  assign req_sc_res = cur_code;
  assign req_noresp = !cur_e.cond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpl_valid  <= 1'b0;
      cmpl_seq    <= '0;
      cmpl_cond   <= 1'b0;
      cmpl_sc_res <= '0;
    end else begin
      cmpl_valid <= (accept && !cur_e.cond) || sc_fail;
      if ((accept && !cur_e.cond) || sc_fail) begin
        cmpl_seq    <= cur_e.seq;
        cmpl_cond   <= cur_e.cond;
        cmpl_sc_res <= cur_code;
      end
    end
  end

  a_r6_quiet_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (st_blocked && !req_retry) |-> !req_valid);
  a_r10_cmpl_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !cmpl_cond) |-> $past(req_valid && req_ready));
  a_r4_fail_retires_unsent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cmpl_cond) |-> ($past(!req_valid) && cmpl_sc_res == 2'd0));
  a_r7_unblock_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_blocked) |-> $past(req_retry && req_ready));
endmodule

// File: tb/sim_sq_wb_ctrl.sv
module sim_sq_wb_ctrl;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 0, enq_ready, enq_cond = 0, enq_uncache = 0;
  logic [31:0] enq_addr = 0, enq_data = 0, ll_addr = 0;
  logic [15:0] enq_seq = 0, stall_seq = 0;
  logic        commit_valid = 0, ll_valid = 0, resv_clr = 0, resv_flag;
  logic [31:0] resv_addr, req_addr, req_data;
  logic        stall_set = 0, stalled, replay_valid;
  logic [3:0]  stall_ldidx = 0, replay_ldidx;
  logic        req_valid, req_ready = 0, req_retry = 0, req_cond, req_noresp;
  logic [15:0] req_seq, cmpl_seq;
  logic [1:0]  req_sc_res, cmpl_sc_res;
  logic        st_blocked, cmpl_valid, cmpl_cond;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sq_wb_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_addr(enq_addr),
    .enq_data(enq_data), .enq_seq(enq_seq), .enq_cond(enq_cond),
    .enq_uncache(enq_uncache), .commit_valid(commit_valid),
    .ll_valid(ll_valid), .ll_addr(ll_addr), .resv_clr(resv_clr),
    .resv_flag(resv_flag), .resv_addr(resv_addr),
    .stall_set(stall_set), .stall_seq(stall_seq), .stall_ldidx(stall_ldidx),
    .stalled(stalled), .replay_valid(replay_valid), .replay_ldidx(replay_ldidx),
    .req_valid(req_valid), .req_ready(req_ready), .req_retry(req_retry),
    .req_addr(req_addr), .req_data(req_data), .req_seq(req_seq),
    .req_cond(req_cond), .req_sc_res(req_sc_res), .req_noresp(req_noresp),
    .st_blocked(st_blocked), .cmpl_valid(cmpl_valid), .cmpl_seq(cmpl_seq),
    .cmpl_cond(cmpl_cond), .cmpl_sc_res(cmpl_sc_res)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int seq, input bit cond, input bit unc);
    @(negedge clk);
    enq_valid = 1; enq_seq = 16'(seq); enq_addr = 32'(seq * 16);
    enq_data = 32'(seq + 1000); enq_cond = cond; enq_uncache = unc;
    @(posedge clk); #1 enq_valid = 0;
  endtask

  task automatic commit_one();
    @(negedge clk); commit_valid = 1;
    @(posedge clk); #1 commit_valid = 0;
  endtask

  task automatic pulse_ll(input int a);
    @(negedge clk); ll_valid = 1; ll_addr = 32'(a);
    @(posedge clk); #1 ll_valid = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); resv_clr = 1;
    @(posedge clk); #1 resv_clr = 0;
  endtask

  // Drains n plain stores expected in sequence order from first.
  task automatic drain_expect(input int first, input int n, input string req);
    int got = 0;
    bit have_prev = 0;
    int prev = 0;
    for (int c = 0; c < 60 && got < n; c++) begin
      @(negedge clk); req_ready = 1; commit_valid = 1; #1;
      if (have_prev) chk(cmpl_valid && cmpl_seq == 16'(prev) && !cmpl_cond,
                         "R10", "completion seq", cmpl_seq, prev);
      have_prev = 0;
      if (req_valid) begin
        chk(req_seq == 16'(first + got), req, "order seq", req_seq, first + got);
        chk(req_noresp == 1, "R10", "noresp", req_noresp, 1);
        prev = first + got; have_prev = 1; got++;
      end
    end
    @(negedge clk); req_ready = 0; commit_valid = 0; #1;
    if (have_prev) chk(cmpl_valid && cmpl_seq == 16'(prev), "R10", "last completion",
                       cmpl_seq, prev);
    chk(got == n, req, "drained count", got, n);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(enq_ready == 1, "R1", "reset enq_ready", enq_ready, 1);
    chk(req_valid == 0, "R1", "reset req_valid", req_valid, 0);
    chk(resv_flag == 0, "R5", "reset flag", resv_flag, 0);
    chk(st_blocked == 0 && stalled == 0, "R6", "reset blocked/stalled", st_blocked, 0);
  endtask

  task automatic t_order();
    for (int i = 1; i <= DEPTH; i++) push(i, 0, 0);
    @(negedge clk); #1;
    chk(enq_ready == 0, "R1", "full enq_ready", enq_ready, 0);
    chk(req_valid == 0, "R1", "uncommitted not sent", req_valid, 0);
    push(99, 0, 0);
    drain_expect(1, DEPTH, "R1");
    chk(enq_ready == 1, "R1", "ready after drain", enq_ready, 1);
    for (int i = 9; i <= 13; i++) push(i, 0, 0);
    drain_expect(9, 5, "R1");
    commit_one();
    @(negedge clk); #1;
    chk(req_valid == 0, "R1", "idle commit no request", req_valid, 0);
  endtask

  task automatic t_refuse();
    push(20, 0, 0); push(21, 0, 0);
    @(negedge clk); commit_valid = 1; req_ready = 0;
    @(negedge clk); #1;
    chk(req_valid && req_seq == 20, "R6", "first offer", req_seq, 20);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(st_blocked == 1, "R6", "blocked", st_blocked, 1);
      chk(req_valid == 0, "R6", "quiet while blocked", req_valid, 0);
    end
    commit_valid = 0;
    @(negedge clk); req_retry = 1; req_ready = 0; #1;
    chk(req_valid && req_seq == 20, "R7", "retry offer", req_seq, 20);
    @(negedge clk); req_retry = 0; #1;
    chk(st_blocked == 1 && req_valid == 0, "R7", "still blocked", st_blocked, 1);
    @(negedge clk); req_retry = 1; req_ready = 1; #1;
    chk(req_valid && req_seq == 20, "R7", "retry offer 2", req_seq, 20);
    @(negedge clk); req_retry = 0; #1;
    chk(st_blocked == 0, "R7", "unblocked", st_blocked, 0);
    chk(cmpl_valid && cmpl_seq == 20, "R10", "parked completion", cmpl_seq, 20);
    chk(req_valid && req_seq == 21, "R7", "resume drain", req_seq, 21);
    @(negedge clk); req_ready = 0; req_retry = 1; #1;
    chk(req_valid == 0, "R8", "retry on empty", req_valid, 0);
    @(negedge clk); req_retry = 0; #1;
    chk(cmpl_valid == 0 && st_blocked == 0, "R8", "no effect", cmpl_valid, 0);
  endtask

  task automatic t_sc();
    pulse_clr();
    push(30, 1, 0); push(31, 0, 0);
    @(negedge clk); commit_valid = 1; req_ready = 1;
    @(negedge clk); #1;
    chk(req_valid == 0, "R4", "failed SC unsent", req_valid, 0);
    @(negedge clk); #1;
    chk(cmpl_valid && cmpl_seq == 30, "R4", "fail completion seq", cmpl_seq, 30);
    chk(cmpl_cond == 1 && cmpl_sc_res == 0, "R4", "fail code", cmpl_sc_res, 0);
    chk(req_valid && req_seq == 31, "R4", "pointer advanced", req_seq, 31);
    commit_valid = 0;
    @(negedge clk); req_ready = 0;
    pulse_ll(32'h1234);
    @(negedge clk); #1;
    chk(resv_flag == 1, "R5", "flag set", resv_flag, 1);
    chk(resv_addr == 32'h1234, "R5", "addr", resv_addr, 32'h1234);
    push(32, 1, 0); commit_one();
    @(negedge clk); req_ready = 1; #1;
    chk(req_valid && req_sc_res == 1, "R3", "success code", req_sc_res, 1);
    chk(req_noresp == 0, "R3", "SC needs response", req_noresp, 0);
    @(negedge clk); req_ready = 0; #1;
    chk(cmpl_valid == 0, "R3", "no completion", cmpl_valid, 0);
    push(33, 1, 1); commit_one();
    @(negedge clk); req_ready = 1; #1;
    chk(req_valid && req_sc_res == 2, "R2", "uncacheable code", req_sc_res, 2);
    @(negedge clk); req_ready = 0;
    @(negedge clk); ll_valid = 1; resv_clr = 1;
    @(posedge clk); #1 ll_valid = 0; resv_clr = 0;
    chk(resv_flag == 1, "R5", "ll beats clear", resv_flag, 1);
    pulse_clr();
    @(negedge clk); #1;
    chk(resv_flag == 0, "R5", "flag cleared", resv_flag, 0);
  endtask

  task automatic t_freeze();
    pulse_ll(32'h40);
    push(60, 1, 0); commit_one();
    @(negedge clk); req_ready = 0; #1;
    chk(req_valid && req_sc_res == 1, "R11", "first code", req_sc_res, 1);
    pulse_clr();
    @(negedge clk); req_retry = 1; req_ready = 1; #1;
    chk(resv_flag == 0, "R11", "flag dropped", resv_flag, 0);
    chk(req_valid && req_sc_res == 1, "R11", "code frozen", req_sc_res, 1);
    @(negedge clk); req_retry = 0; req_ready = 0; #1;
    chk(st_blocked == 0, "R11", "unblocked", st_blocked, 0);
  endtask

  task automatic t_stall();
    @(negedge clk); stall_set = 1; stall_seq = 40; stall_ldidx = 5;
    @(posedge clk); #1 stall_set = 0;
    push(40, 0, 0); commit_one();
    @(negedge clk); #1;
    chk(stalled == 1, "R9", "stalled", stalled, 1);
    req_ready = 1;
    @(negedge clk); req_ready = 0; #1;
    chk(replay_valid && replay_ldidx == 5, "R9", "replay idx", replay_ldidx, 5);
    chk(stalled == 0, "R9", "stall cleared", stalled, 0);
    @(negedge clk); #1;
    chk(replay_valid == 0, "R9", "single pulse", replay_valid, 0);
    pulse_clr();
    @(negedge clk); stall_set = 1; stall_seq = 41; stall_ldidx = 3;
    @(posedge clk); #1 stall_set = 0;
    push(41, 1, 0); commit_one();
    @(negedge clk); @(negedge clk); #1;
    chk(cmpl_valid && cmpl_seq == 41, "R4", "SC 41 retired", cmpl_seq, 41);
    chk(stalled == 1 && replay_valid == 0, "R4", "no release by fail", stalled, 1);
  endtask

  task automatic t_same_cycle();
    pulse_clr();
    push(50, 1, 0);
    @(negedge clk); commit_valid = 1;
    @(posedge clk); #1 commit_valid = 0; ll_valid = 1; ll_addr = 32'h77; req_ready = 1;
    #1 chk(req_valid == 0, "R4", "SC unsent with LL same cycle", req_valid, 0);
    @(posedge clk); #1 ll_valid = 0; req_ready = 0;
    chk(cmpl_valid && cmpl_seq == 50 && cmpl_sc_res == 0, "R4", "old flag used",
        cmpl_sc_res, 0);
    chk(resv_flag == 1, "R5", "flag set after overlap", resv_flag, 1);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_order();
    t_refuse();
    t_sc();
    t_freeze();
    t_stall();
    t_same_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule